// File: doc/BRIEF.md
# ADC Input Channel Sequencer

This block picks the analog input that feeds the sample/hold on each acquire/convert cycle of an analog-to-digital converter. It drives a channel number and a group identifier. Group A and group B each have a fixed channel setting. The converter control logic reads these outputs while it samples. It pulses `seq_done` when a conversion finishes and `irq_pulse` when an interrupt event closes a batch of samples.

There are two modes, and they can be used together. With alternation on, samples switch between group A and group B. Every batch starts on group A. With scanning on, each group A sample takes the next enabled bit of a 16-bit mask instead of the fixed group A channel. The scan runs from low inputs to high inputs, wraps round, and restarts at the lowest enabled input after each interrupt. The block also raises a flag when the selected input has no physical pin, so that the result path can force that conversion to zero.

All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure. The outputs are combinational from the registered state and the configuration inputs. A strobe changes them one clock after the edge that samples it.

Top module: `adc_chan_seq`

## Requirements
- R1: After reset, `sel_grp` is 0 (group A) and, with scanning off, `sel_chan` equals `chan_a`.
- R2: With `alt_en` low, `sel_grp` stays 0 and `sel_chan` stays at the group A selection for every sample, across any number of `seq_done` pulses.
- R3: With `alt_en` high, the first sample after an `irq_pulse` is group A (`sel_grp`=0). Each `seq_done` then flips the group, so the sequence runs A, B, A, B.
- R4: While `sel_grp` is 1 (group B), `sel_chan` equals `chan_b`. Scanning never applies to group B.
- R5: With `scan_en` high and a non-zero `scan_mask`, the group A channel is the set bit that comes next above the previous group A channel. Each completed group A sample moves it one set bit upward.
- R6: `irq_pulse` restarts the scan: the next group A channel is the lowest set bit of `scan_mask`, and the group returns to A.
- R7: After the highest set mask bit, the next group A sample wraps to the lowest set bit.
- R8: With `scan_en` high and `scan_mask` all zero, group A uses `chan_a`.
- R9: When alternation and scanning are both on, group B samples do not advance the scan position.
- R10: `no_pin` is 1 exactly when `sel_chan` is 13, 14 or 15 (inputs with no pin, whose result must read as zero), and 0 for channels 0 to 12.
- R11: When `seq_done` and `irq_pulse` arrive in the same cycle, the restart wins. The next sample is group A on the lowest enabled scan input, or on `chan_a` if scanning is off.
- R12: When fewer samples are taken between interrupts than there are enabled mask bits, the higher enabled inputs are never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_en | input | 1 | Alternate between group A and group B |
| scan_en | input | 1 | Scan group A through `scan_mask` |
| chan_a | input | 4 | Fixed group A channel |
| chan_b | input | 4 | Fixed group B channel |
| scan_mask | input | 16 | One bit per input enabled for scanning |
| seq_done | input | 1 | One-cycle strobe: current sample/convert finished |
| irq_pulse | input | 1 | One-cycle strobe: interrupt event, restart batch |
| sel_chan | output | 4 | Channel for the current sample |
| sel_grp | output | 1 | Group of the current sample, 0 = A, 1 = B |
| no_pin | output | 1 | Selected channel has no pin; force result to zero |

## Verification
The two functions that can fall in the same cycle are the per-sample advance, driven by `seq_done`, and the batch restart, driven by `irq_pulse`. The bench first moves the scan and the group phase away from their start values. It then raises both strobes on the same clock edge, once with scanning alone and once with alternation and scanning together. The case is judged correct only if, one cycle later, the outputs show group A and the lowest enabled input, with no sign of the advance.

// File: rtl/adc_chan_seq_pkg.sv
package adc_chan_seq_pkg;

  typedef enum logic {
    GRP_A = 1'b0,
    GRP_B = 1'b1
  } grp_e;

endpackage

// File: rtl/chseq_scan_pick.sv
module chseq_scan_pick #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W-1:0]   base,
  output logic [CH_W-1:0]   lowest,
  output logic [CH_W-1:0]   next_up
);

  logic [NUM_CH-1:0] above;

  // Qualify each mask bit by its position relative to the base channel
  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_above
    assign above[gi] = mask[gi] && (CH_W'(gi) > base);
  end

  function automatic logic [CH_W-1:0] first_set(input logic [NUM_CH-1:0] vec);
    logic [CH_W-1:0] idx;
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (vec[i]) idx = CH_W'(i);
    end
    return idx;
  endfunction

  always_comb begin
    lowest  = first_set(mask);
    next_up = (|above) ? first_set(above) : lowest;
  end

endmodule

// File: rtl/chseq_scan_ptr.sv
module chseq_scan_ptr #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] mask,
  input  logic              advance,
  input  logic              restart,
  output logic [CH_W-1:0]   cur
);

  logic [CH_W-1:0] ptr_q;
  logic            fresh_q;
  logic [CH_W-1:0] lowest;
  logic [CH_W-1:0] next_up;

  chseq_scan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .mask    (mask),
    .base    (cur),
    .lowest  (lowest),
    .next_up (next_up)
  );

  assign cur = fresh_q ? lowest : ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      fresh_q <= 1'b1;
    end else if (restart) begin
      ptr_q   <= '0;
      fresh_q <= 1'b1;
    end else if (advance) begin
      ptr_q   <= next_up;
      fresh_q <= 1'b0;
    end
  end

  // R6
  scan_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> fresh_q);

  // R5 R7
  scan_forward_or_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && $stable(mask)) |=>
      (ptr_q > $past(cur)) || (ptr_q == $past(lowest)));

endmodule

// File: rtl/chseq_alt_phase.sv
module chseq_alt_phase
  import adc_chan_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic restart,
  output grp_e phase
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= GRP_A;
    else if (restart) phase <= GRP_A;
    else if (step)    phase <= (phase == GRP_A) ? GRP_B : GRP_A;
  end

  // R3 R6
  phase_clear_on_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase == GRP_A));

  // R3
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart) |=> (phase != $past(phase)));

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(phase));

endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
  import adc_chan_seq_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int NOPIN_FIRST = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alt_en,
  input  logic                      scan_en,
  input  logic [$clog2(NUM_CH)-1:0] chan_a,
  input  logic [$clog2(NUM_CH)-1:0] chan_b,
  input  logic [NUM_CH-1:0]         scan_mask,
  input  logic                      seq_done,
  input  logic                      irq_pulse,
  output logic [$clog2(NUM_CH)-1:0] sel_chan,
  output logic                      sel_grp,
  output logic                      no_pin
);

  localparam int              CH_W     = $clog2(NUM_CH);
  localparam logic [CH_W-1:0] NOPIN_CH = CH_W'(NOPIN_FIRST);

  grp_e            phase;
  grp_e            grp;
  logic            scan_active;
  logic            advance;
  logic [CH_W-1:0] scan_cur;

  assign scan_active = scan_en && (|scan_mask);
  assign grp         = (alt_en && phase == GRP_B) ? GRP_B : GRP_A;
  // The restart has priority: a simultaneous completion does not advance
  assign advance     = seq_done && !irq_pulse && (grp == GRP_A) && scan_active;

  chseq_alt_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (seq_done && alt_en),
    .restart (irq_pulse),
    .phase   (phase)
  );

  chseq_scan_ptr #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask    (scan_mask),
    .advance (advance),
    .restart (irq_pulse),
    .cur     (scan_cur)
  );

  always_comb begin
    if (grp == GRP_B)     sel_chan = chan_b;
    else if (scan_active) sel_chan = scan_cur;
    else                  sel_chan = chan_a;
  end

  assign sel_grp = grp;
  assign no_pin  = (sel_chan >= NOPIN_CH);

  // R2
  grp_a_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_en && !scan_en) |-> (sel_grp == 1'b0 && sel_chan == chan_a));

  // R11
  irq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && seq_done) |=> (sel_grp == 1'b0));

  // R2 R5
  hold_without_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_done && !irq_pulse) |=>
      (!$stable(alt_en) || !$stable(scan_en) || !$stable(chan_a) ||
       !$stable(chan_b) || !$stable(scan_mask) || $stable(sel_chan)));

endmodule

// File: tb/adc_chan_seq_tb.sv
module adc_chan_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alt_en = 1'b0;
  logic        scan_en = 1'b0;
  logic [3:0]  chan_a = 4'd5;
  logic [3:0]  chan_b = 4'd9;
  logic [15:0] scan_mask = 16'h0000;
  logic        seq_done = 1'b0;
  logic        irq_pulse = 1'b0;
  logic [3:0]  sel_chan;
  logic        sel_grp;
  logic        no_pin;

  int applied = 0;
  int miscompares = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  adc_chan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .alt_en(alt_en), .scan_en(scan_en),
    .chan_a(chan_a), .chan_b(chan_b), .scan_mask(scan_mask),
    .seq_done(seq_done), .irq_pulse(irq_pulse),
    .sel_chan(sel_chan), .sel_grp(sel_grp), .no_pin(no_pin)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  task automatic check(input string req, input logic [3:0] ech, input logic egrp);
    logic enp;
    enp = (ech >= 4'd13);
    applied++;
    if (sel_chan !== ech || sel_grp !== egrp || no_pin !== enp) begin
      miscompares++;
      $display("FAIL %s: chan/grp/no_pin = %0d/%0d/%0d expected %0d/%0d/%0d",
               req, sel_chan, sel_grp, no_pin, ech, egrp, enp);
    end
  endtask

  // Strobes are driven at the falling edge; outputs are sampled one cycle later
  task automatic pulse(input logic d, input logic i);
    @(negedge clk);
    seq_done  = d;
    irq_pulse = i;
    @(negedge clk);
    seq_done  = 1'b0;
    irq_pulse = 1'b0;
    #1;
  endtask

  task automatic set_cfg(input logic alt, input logic scn, input logic [3:0] a,
                         input logic [3:0] b, input logic [15:0] m);
    @(negedge clk);
    alt_en = alt; scan_en = scn; chan_a = a; chan_b = b; scan_mask = m;
    #1;
  endtask

  task automatic t_reset;
    #1 check("R1 reset", 4'd5, 1'b0);
  endtask

  task automatic t_fixed;
    set_cfg(1'b0, 1'b0, 4'd6, 4'd9, 16'h0000);
    for (int k = 0; k < 4; k++) begin
      pulse(1'b1, 1'b0);
      check("R2 fixed group A", 4'd6, 1'b0);
    end
  endtask

  task automatic t_alt;
    set_cfg(1'b1, 1'b0, 4'd3, 4'd9, 16'h0000);
    pulse(1'b0, 1'b1);
    check("R3 first after irq is A", 4'd3, 1'b0);
    pulse(1'b1, 1'b0);
    check("R4 group B uses chan_b", 4'd9, 1'b1);
    pulse(1'b1, 1'b0);
    check("R3 back to A", 4'd3, 1'b0);
    pulse(1'b1, 1'b0);
    check("R3 B again", 4'd9, 1'b1);
    pulse(1'b0, 1'b1);
    check("R3 irq returns to A", 4'd3, 1'b0);
  endtask

  task automatic t_scan;
    // mask bits 2, 5, 9, 11
    set_cfg(1'b0, 1'b1, 4'd7, 4'd9, 16'h0A24);
    pulse(1'b0, 1'b1);
    check("R6 scan starts lowest", 4'd2, 1'b0);
    pulse(1'b1, 1'b0);
    check("R5 scan step", 4'd5, 1'b0);
    pulse(1'b1, 1'b0);
    check("R5 scan step", 4'd9, 1'b0);
    pulse(1'b1, 1'b0);
    check("R5 scan step", 4'd11, 1'b0);
    pulse(1'b1, 1'b0);
    check("R7 wrap to lowest", 4'd2, 1'b0);
  endtask

  task automatic t_short_batch;
    set_cfg(1'b0, 1'b1, 4'd7, 4'd9, 16'h0A24);
    for (int b = 0; b < 3; b++) begin
      pulse(1'b0, 1'b1);
      check("R12 batch start", 4'd2, 1'b0);
      pulse(1'b1, 1'b0);
      check("R12 second sample", 4'd5, 1'b0);
    end
    pulse(1'b0, 1'b1);
    check("R6 restart after short batch", 4'd2, 1'b0);
  endtask

  task automatic t_empty;
    set_cfg(1'b0, 1'b1, 4'd7, 4'd9, 16'h0000);
    check("R8 empty mask uses chan_a", 4'd7, 1'b0);
    pulse(1'b1, 1'b0);
    check("R8 empty mask after done", 4'd7, 1'b0);
  endtask

  task automatic t_alt_scan;
    set_cfg(1'b1, 1'b1, 4'd7, 4'd9, 16'h0A24);
    pulse(1'b0, 1'b1);
    check("R9 A lowest", 4'd2, 1'b0);
    pulse(1'b1, 1'b0);
    check("R9 B", 4'd9, 1'b1);
    pulse(1'b1, 1'b0);
    check("R9 A next bit", 4'd5, 1'b0);
    pulse(1'b1, 1'b0);
    check("R9 B", 4'd9, 1'b1);
    pulse(1'b1, 1'b0);
    check("R9 A unaffected by B", 4'd9, 1'b0);
  endtask

  task automatic t_nopin;
    for (int c = 11; c < 16; c++) begin
      set_cfg(1'b0, 1'b0, 4'(c), 4'd9, 16'h0000);
      check("R10 no_pin on fixed channel", 4'(c), 1'b0);
    end
    // bits 12 and 14
    set_cfg(1'b0, 1'b1, 4'd0, 4'd9, 16'h5000);
    pulse(1'b0, 1'b1);
    check("R10 scan 12", 4'd12, 1'b0);
    pulse(1'b1, 1'b0);
    check("R10 scan 14 no pin", 4'd14, 1'b0);
  endtask

  task automatic t_collide;
    set_cfg(1'b0, 1'b1, 4'd7, 4'd9, 16'h0A24);
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    check("R11 setup", 4'd5, 1'b0);
    pulse(1'b1, 1'b1);
    check("R11 irq beats done scan", 4'd2, 1'b0);
    set_cfg(1'b1, 1'b1, 4'd7, 4'd9, 16'h0A24);
    pulse(1'b1, 1'b0);
    check("R11 setup alt B", 4'd9, 1'b1);
    pulse(1'b1, 1'b1);
    check("R11 irq beats done alt", 4'd2, 1'b0);
    set_cfg(1'b1, 1'b0, 4'd4, 4'd9, 16'h0A24);
    pulse(1'b1, 1'b0);
    check("R11 setup alt fixed", 4'd9, 1'b1);
    pulse(1'b1, 1'b1);
    check("R11 irq beats done fixed", 4'd4, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fixed();
    t_alt();
    t_scan();
    t_short_batch();
    t_empty();
    t_alt_scan();
    t_nopin();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule